// File: doc/BRIEF.md
# Saturating-Result Hazard Interlock

This block sits beside the Decode stage of a five-stage in-order pipeline (Fetch, Decode, Execute, Memory, Writeback). It keeps a small shadow of the instructions in Execute, Memory and Writeback, recording for each one whether it is valid, whether it writes a register, which register that is, and what kind of operation it is. Each cycle it compares the source registers of the instruction in Decode against that shadow. From the comparison it decides whether the Decode instruction must wait, and which in-flight stage should supply each of its operands.

Saturating add and subtract, including the doubling forms, occupy both Execute and Memory. Their result exists only at the end of Memory. Loads behave the same way. A consumer that first uses such a result in its Execute cycle is held for exactly one cycle, and a bubble enters Execute. A consumer that first uses it in Memory, such as store data or a multiply-accumulate addend, is forwarded without delay. Results of ordinary single-cycle operations forward from Execute with no wait.

The Decode side is a valid/ready handshake. `dec_valid` marks a real instruction in Decode. `dec_ready` low is the stall: Fetch and Decode hold, and the upstream logic must keep every `dec_*` input unchanged until a cycle with both signals high. That cycle is when the instruction moves into Execute. `dec_ready` is never low while `dec_valid` is low.

Top module: `satop_interlock`

## Requirements
- R1: After reset, `ex_valid` is 0 and, with `dec_valid` low, `dec_ready` is 1.
- R2: `dec_ready` goes to 0 when `dec_valid` is 1 and a valid source whose late flag is 0 (needed in Execute) names the destination of a valid, register-writing saturating-class instruction (kind code 1) now in Execute.
- R3: The same stall happens when the Execute instruction is a load (kind code 2).
- R4: A stall lasts exactly one cycle. In the next cycle, with Decode held, `ex_valid` is 0 (a bubble) and `dec_ready` is 1.
- R5: A matching source whose late flag is 1 (needed first in Memory) never stalls. Its select is 1 (from Execute).
- R6: A producer of kind ALU (code 0) or other (code 3) never causes a stall. A matching Execute-need source gets select 1.
- R7: A source slot with its valid bit 0, or naming register 15, never stalls and gets select 0. A producer that does not write a register is never matched.
- R8: Each source has a 2-bit select at bits [2i+1:2i] of `fwd_sel`. The codes are 0 none, 1 from Execute, 2 from Memory, 3 from Writeback. When several stages match, the youngest one wins.
- R9: A decode transfer (`dec_valid` and `dec_ready` both 1) makes `ex_valid` 1 in the next cycle. With no transfer, `ex_valid` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_valid | input | 1 | Decode holds a real instruction |
| dec_ready | output | 1 | Decode may advance; low is the stall that holds Fetch and Decode |
| dec_kind | input | 2 | Operation kind: 0 ALU, 1 saturating, 2 load, 3 other |
| dec_wr | input | 1 | Instruction writes a destination register |
| dec_dst | input | REG_W | Destination register |
| src_v | input | NUM_SRC | Per-source valid |
| src_reg | input | NUM_SRC*REG_W | Source registers, slot i at [REG_W*i +: REG_W] |
| src_late | input | NUM_SRC | Per-source: 1 = first needed in Memory, 0 = in Execute |
| ex_valid | output | 1 | Execute stage holds a real instruction (0 = bubble) |
| fwd_sel | output | 2*NUM_SRC | Per-source forward select |

## Verification
The main function is tried with a saturating producer followed by four kinds of consumer. A subtract reads it in Execute. A store reads it as data. A multiply-accumulate reads it as the addend. The fourth consumer does not use it at all. Together these separate the stall from the forward-only cases. Loads and ordinary ALU producers followed by the same Execute-need consumer show that the stall depends on the producer's kind. Producers placed two and three slots ahead, and two matching producers in a row, exercise the select codes and the youngest-wins priority. Register 15, invalid slots and non-writing producers confirm that a register number match alone never triggers a hazard.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
  typedef enum logic [1:0] {
    K_ALU   = 2'd0,
    K_SAT   = 2'd1,
    K_LOAD  = 2'd2,
    K_OTHER = 2'd3
  } op_kind_e;

  typedef enum logic [1:0] {
    F_NONE = 2'd0,
    F_EX   = 2'd1,
    F_MEM  = 2'd2,
    F_WB   = 2'd3
  } fwd_e;

  typedef struct packed {
    logic     v;
    logic     wr;
    op_kind_e kind;
  } stage_t;

  localparam int unsigned NUM_TRACKED = 3;  // Execute, Memory, Writeback
endpackage

// File: rtl/ilk_stage_track.sv
module ilk_stage_track
  import ilk_pkg::*;
#(
  parameter int unsigned REG_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  stage_t             in_info,
  input  logic [REG_W-1:0]   in_dst,
  output stage_t             info [NUM_TRACKED],
  output logic [REG_W-1:0]   dst  [NUM_TRACKED]
);
  for (genvar s = 0; s < NUM_TRACKED; s++) begin : g_stage
    stage_t           nxt_info;
    logic [REG_W-1:0] nxt_dst;
    if (s == 0) begin : g_head
      assign nxt_info = in_info;
      assign nxt_dst  = in_dst;
    end else begin : g_tail
      assign nxt_info = info[s-1];
      assign nxt_dst  = dst[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        info[s] <= '{v: 1'b0, wr: 1'b0, kind: K_ALU};
        dst[s]  <= '0;
      end else begin
        info[s] <= nxt_info;
        dst[s]  <= nxt_dst;
      end
    end
  end
endmodule

// File: rtl/ilk_src_cmp.sv
module ilk_src_cmp
  import ilk_pkg::*;
#(
  parameter int unsigned REG_W  = 4,
  parameter int unsigned PC_REG = 15
) (
  input  logic             s_v,
  input  logic [REG_W-1:0] s_reg,
  input  logic             s_late,
  input  stage_t           info [NUM_TRACKED],
  input  logic [REG_W-1:0] dst  [NUM_TRACKED],
  output fwd_e             fwd,
  output logic             need_stall
);
  logic active;
  logic [NUM_TRACKED-1:0] hit;

  assign active = s_v && (s_reg != REG_W'(PC_REG));

  for (genvar s = 0; s < NUM_TRACKED; s++) begin : g_hit
    assign hit[s] = active && info[s].v && info[s].wr && (dst[s] == s_reg);
  end

  always_comb begin
    if (hit[0])      fwd = F_EX;
    else if (hit[1]) fwd = F_MEM;
    else if (hit[2]) fwd = F_WB;
    else             fwd = F_NONE;
  end

  assign need_stall = hit[0] && !s_late &&
                      ((info[0].kind == K_SAT) || (info[0].kind == K_LOAD));
endmodule

// File: rtl/satop_interlock.sv
module satop_interlock
  import ilk_pkg::*;
#(
  parameter int unsigned NUM_SRC = 3,
  parameter int unsigned REG_W   = 4,
  parameter int unsigned PC_REG  = 15
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     dec_valid,
  output logic                     dec_ready,
  input  logic [1:0]               dec_kind,
  input  logic                     dec_wr,
  input  logic [REG_W-1:0]         dec_dst,
  input  logic [NUM_SRC-1:0]       src_v,
  input  logic [NUM_SRC*REG_W-1:0] src_reg,
  input  logic [NUM_SRC-1:0]       src_late,
  output logic                     ex_valid,
  output logic [2*NUM_SRC-1:0]     fwd_sel
);
  stage_t           trk_info [NUM_TRACKED];
  logic [REG_W-1:0] trk_dst  [NUM_TRACKED];
  logic [NUM_SRC-1:0] src_stall;
  logic   stall;
  stage_t adv_info;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    fwd_e f;
    ilk_src_cmp #(.REG_W(REG_W), .PC_REG(PC_REG)) u_cmp (
      .s_v        (src_v[i]),
      .s_reg      (src_reg[REG_W*i +: REG_W]),
      .s_late     (src_late[i]),
      .info       (trk_info),
      .dst        (trk_dst),
      .fwd        (f),
      .need_stall (src_stall[i])
    );
    assign fwd_sel[2*i +: 2] = f;
  end

  assign stall     = dec_valid && (|src_stall);
  assign dec_ready = !stall;

  // A stalled instruction stays in Decode; Execute receives a bubble.
  assign adv_info = '{v: dec_valid && !stall, wr: dec_wr, kind: op_kind_e'(dec_kind)};

  ilk_stage_track #(.REG_W(REG_W)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_info (adv_info),
    .in_dst  (dec_dst),
    .info    (trk_info),
    .dst     (trk_dst)
  );

  assign ex_valid = trk_info[0].v;
endmodule

// File: rtl/ilk_checker.sv
module ilk_checker #(
  parameter int unsigned NUM_SRC = 3,
  parameter int unsigned REG_W   = 4,
  parameter int unsigned PC_REG  = 15
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     dec_valid,
  input logic                     dec_ready,
  input logic [NUM_SRC-1:0]       src_v,
  input logic [NUM_SRC*REG_W-1:0] src_reg,
  input logic                     ex_valid,
  input logic [2*NUM_SRC-1:0]     fwd_sel
);
  assert_stall_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_ready |=> dec_ready);

  assert_bubble_after_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_ready |=> !ex_valid);

  assert_transfer_enters_ex_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_ready) |=> ex_valid);

  assert_idle_no_ex_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |=> !ex_valid);

  assert_no_stall_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> dec_ready);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src_chk
    assert_dead_slot_none_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!src_v[i] || src_reg[REG_W*i +: REG_W] == REG_W'(PC_REG)) |-> fwd_sel[2*i +: 2] == 2'd0);
  end
endmodule

bind satop_interlock ilk_checker #(.NUM_SRC(NUM_SRC), .REG_W(REG_W), .PC_REG(PC_REG)) u_ilk_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dec_valid (dec_valid),
  .dec_ready (dec_ready),
  .src_v     (src_v),
  .src_reg   (src_reg),
  .ex_valid  (ex_valid),
  .fwd_sel   (fwd_sel)
);

// File: tb/tb_satop_interlock.sv
module tb_satop_interlock;
  localparam int NS = 3;
  localparam int RW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_valid = 1'b0, dec_wr = 1'b0;
  logic [1:0] dec_kind = 2'd0;
  logic [RW-1:0] dec_dst = '0;
  logic [NS-1:0] src_v = '0, src_late = '0;
  logic [NS*RW-1:0] src_reg = '0;
  logic dec_ready, ex_valid;
  logic [2*NS-1:0] fwd_sel;

  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  satop_interlock dut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_kind(dec_kind), .dec_wr(dec_wr), .dec_dst(dec_dst), .src_v(src_v),
    .src_reg(src_reg), .src_late(src_late), .ex_valid(ex_valid), .fwd_sel(fwd_sel)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Present one instruction in Decode, sampled 1 ns after the falling edge.
  task automatic put(input logic [1:0] k, input logic w, input int d,
                     input logic [2:0] sv, input int s0, input int s1, input int s2,
                     input logic [2:0] late);
    @(negedge clk);
    dec_valid = 1'b1; dec_kind = k; dec_wr = w; dec_dst = RW'(d);
    src_v = sv; src_late = late;
    src_reg = {RW'(s2), RW'(s1), RW'(s0)};
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dec_valid = 1'b0; src_v = '0; dec_wr = 1'b0;
      #1;
    end
  endtask

  function automatic int sel(input int i);
    return int'(fwd_sel[2*i +: 2]);
  endfunction

  task automatic t_sat_then_sub;
    put(2'd1, 1, 0, 3'b000, 0, 0, 0, 3'b000);
    put(2'd0, 1, 4, 3'b011, 0, 3, 0, 3'b000);
    chk("R2 sat->sub stall", dec_ready, 0);
    @(negedge clk); #1;
    chk("R4 bubble in Execute", ex_valid, 0);
    chk("R4 stall released", dec_ready, 1);
    chk("R8 after stall select Memory", sel(0), 2);
    idle(3);
  endtask

  task automatic t_sat_then_store;
    put(2'd1, 1, 0, 3'b000, 0, 0, 0, 3'b000);
    put(2'd3, 0, 0, 3'b011, 8, 0, 0, 3'b010);
    chk("R5 store data no stall", dec_ready, 1);
    chk("R5 store data select Execute", sel(1), 1);
    idle(3);
  endtask

  task automatic t_sat_then_mla;
    put(2'd1, 1, 0, 3'b000, 0, 0, 0, 3'b000);
    put(2'd3, 1, 0, 3'b111, 3, 4, 0, 3'b100);
    chk("R5 mla addend no stall", dec_ready, 1);
    chk("R5 mla addend select Execute", sel(2), 1);
    chk("R8 mla unrelated select none", sel(0), 0);
    idle(3);
  endtask

  task automatic t_independent;
    put(2'd0, 1, 1, 3'b000, 0, 0, 0, 3'b000);
    put(2'd0, 1, 2, 3'b011, 3, 4, 0, 3'b000);
    chk("R6 independent no stall", dec_ready, 1);
    chk("R8 independent selects none", int'(fwd_sel), 0);
    @(negedge clk); dec_valid = 1'b0; #1;
    chk("R9 transfer enters Execute", ex_valid, 1);
    idle(3);
    chk("R9 drained Execute empty", ex_valid, 0);
  endtask

  task automatic t_alu_then_use;
    put(2'd0, 1, 6, 3'b000, 0, 0, 0, 3'b000);
    put(2'd0, 1, 7, 3'b001, 6, 0, 0, 3'b000);
    chk("R6 ALU producer no stall", dec_ready, 1);
    chk("R6 ALU producer select Execute", sel(0), 1);
    idle(3);
  endtask

  task automatic t_load_then_use;
    put(2'd2, 1, 9, 3'b000, 0, 0, 0, 3'b000);
    put(2'd0, 1, 7, 3'b010, 0, 9, 0, 3'b000);
    chk("R3 load->use stall", dec_ready, 0);
    idle(3);
  endtask

  task automatic t_ignored;
    put(2'd1, 1, 15, 3'b000, 0, 0, 0, 3'b000);
    put(2'd0, 1, 2, 3'b001, 15, 0, 0, 3'b000);
    chk("R7 register 15 no stall", dec_ready, 1);
    chk("R7 register 15 select none", sel(0), 0);
    put(2'd1, 1, 0, 3'b000, 0, 0, 0, 3'b000);
    put(2'd0, 1, 2, 3'b000, 0, 0, 0, 3'b000);
    chk("R7 invalid slot no stall", dec_ready, 1);
    chk("R7 invalid slot select none", sel(0), 0);
    idle(3);
    put(2'd1, 0, 5, 3'b000, 0, 0, 0, 3'b000);
    put(2'd0, 1, 2, 3'b001, 5, 0, 0, 3'b000);
    chk("R7 non-writing producer no stall", dec_ready, 1);
    chk("R7 non-writing producer select none", sel(0), 0);
    idle(3);
  endtask

  task automatic t_distance;
    put(2'd1, 1, 5, 3'b000, 0, 0, 0, 3'b000);
    put(2'd0, 1, 6, 3'b000, 0, 0, 0, 3'b000);
    put(2'd0, 1, 7, 3'b001, 5, 0, 0, 3'b000);
    chk("R2 distance two no stall", dec_ready, 1);
    chk("R8 distance two select Memory", sel(0), 2);
    idle(3);
    put(2'd1, 1, 5, 3'b000, 0, 0, 0, 3'b000);
    put(2'd0, 1, 6, 3'b000, 0, 0, 0, 3'b000);
    put(2'd0, 1, 7, 3'b000, 0, 0, 0, 3'b000);
    put(2'd0, 1, 8, 3'b100, 0, 0, 5, 3'b000);
    chk("R8 distance three select Writeback", sel(2), 3);
    idle(3);
    put(2'd0, 1, 1, 3'b000, 0, 0, 0, 3'b000);
    put(2'd0, 1, 1, 3'b000, 0, 0, 0, 3'b000);
    put(2'd0, 1, 2, 3'b001, 1, 0, 0, 3'b000);
    chk("R8 youngest producer wins", sel(0), 1);
    idle(3);
  endtask

  initial begin
    #12;
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 reset Execute empty", ex_valid, 0);
    chk("R1 reset ready", dec_ready, 1);
    t_sat_then_sub();
    t_sat_then_store();
    t_sat_then_mla();
    t_independent();
    t_alu_then_use();
    t_load_then_use();
    t_ignored();
    t_distance();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule